// File: doc/BRIEF.md
# DMA command queue register interface

This block is the software-visible face of a DMA engine's command queue. It is a word-addressed register file behind a 32-bit read/write port. It holds an end pointer, a write pointer, a read pointer, an interrupt enable word and an interrupt status word, and it drives one level interrupt for completion.

Posting a new write pointer marks the queued work as finished straight away. The masked pointer is copied into the read pointer, and the two completion bits (upstream done and downstream done) are set in the status word. A special value written to the read-pointer offset swallows exactly one such completion event. Every other word inside the window is ordinary storage.

The parameter `MAP_SEL` picks one of two register layouts. Each layout has its own offsets, completion bit positions and enable write mask.

Top module: `dmaq_regs`

## Requirements
- R1: After reset, every word in the window reads zero except the status word, which reads 0xF8000000, and `irq` is low.
- R2: A write to the end-pointer word stores only bits 17:0 of the data (mask 0x0003FFFF).
- R3: A write to the write-pointer word stores the data masked to bits 17:0 and, at the same clock edge, places that masked value in the read-pointer word.
- R4: A write of any value other than 0xEE882266 to the read-pointer offset changes no register. Writing 0xEE882266 arms a one-shot flag and also leaves the read-pointer word unchanged.
- R5: A write-pointer write while the flag is armed disarms it and leaves the status word and `irq` unchanged. The next write-pointer write signals completion normally.
- R6: A write-pointer write with the flag disarmed sets both completion bits in the status word (bits 4 and 5 when `MAP_SEL`=0, bits 16 and 17 when `MAP_SEL`=1). If the enable word has either of those bits set, `irq` is high from the next cycle.
- R7: A write to the enable word stores the data ANDed with 0xBFEFF07F (`MAP_SEL`=0) or 0x017003FF (`MAP_SEL`=1).
- R8: A status write whose data has any completion bit set clears both completion bits and drops `irq`. A status write with no completion bit set has no effect, and the non-completion status bits never change after reset.
- R9: Any other word inside the 256-byte window stores and returns the full 32-bit value written.
- R10: An access at a byte address of 0x100 or above, or with address bits 1:0 nonzero, reads zero and writes nothing.
- R11: Once raised, `irq` stays high across unrelated writes until a completion-clearing status write or reset.
- R12: The byte offsets for end pointer, write pointer, read pointer, enable and status are 0x14, 0x18, 0x1C, 0x20 and 0x24 when `MAP_SEL`=0, and 0x18, 0x1C, 0x20, 0x38 and 0x3C when `MAP_SEL`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read of the addressed word |
| irq | output | 1 | Completion interrupt, registered level |

## Verification
Write-pointer posts are tried in three states: with the magic flag disarmed, with it armed, and immediately after the one swallowed post. These tell apart a flag that never arms, one that never disarms, and one that blocks the pointer copy as well as the signal. Posts are also made with the enable word empty and with it fully written, which separates setting a status bit from raising `irq`. Both layouts run every scenario. In the second layout the enable mask excludes the completion bits, so `irq` must stay low there. Status writes use no completion bit, one completion bit and all ones, to show that a single bit clears both and that the fixed upper bits survive.

// File: rtl/dmaq_regs.sv
module dmaq_regs #(
  parameter int MAP_SEL   = 0,
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int IW    = $clog2(WORDS);
  localparam int ENDP_W = (MAP_SEL == 0) ? 5 : 6;
  localparam int WRP_W  = (MAP_SEL == 0) ? 6 : 7;
  localparam int RDP_W  = (MAP_SEL == 0) ? 7 : 8;
  localparam int EN_W   = (MAP_SEL == 0) ? 8 : 14;
  localparam int ST_W   = (MAP_SEL == 0) ? 9 : 15;
  localparam logic [31:0] COMP    = (MAP_SEL == 0) ? 32'h0000_0030 : 32'h0003_0000;
  localparam logic [31:0] EN_MASK = (MAP_SEL == 0) ? 32'hBFEF_F07F : 32'h0170_03FF;
  localparam logic [31:0] PTR_MASK = 32'h0003_FFFF;
  localparam logic [31:0] MAGIC    = 32'hEE88_2266;
  localparam logic [31:0] ST_RST   = 32'hF800_0000;

  logic [31:0] mem [WORDS];
  logic        armed;
  logic [IW-1:0] idx;
  logic        in_win, wr_hit;

  assign idx    = addr[IW+1:2];
  assign in_win = (addr < ADDR_W'(WIN_BYTES)) && (addr[1:0] == 2'b00);
  assign wr_hit = wr_en && in_win;
  assign rdata  = in_win ? mem[idx] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 32'h0;
      mem[ST_W] <= ST_RST;
      armed     <= 1'b0;
      irq       <= 1'b0;
    end else if (wr_hit) begin
      if (idx == IW'(ENDP_W)) begin
        mem[ENDP_W] <= wdata & PTR_MASK;
      end else if (idx == IW'(WRP_W)) begin
        mem[WRP_W] <= wdata & PTR_MASK;
        mem[RDP_W] <= wdata & PTR_MASK;
        if (armed) armed <= 1'b0;
        else begin
          mem[ST_W] <= mem[ST_W] | COMP;
          if (|(mem[EN_W] & COMP)) irq <= 1'b1;
        end
      end else if (idx == IW'(RDP_W)) begin
        if (wdata == MAGIC) armed <= 1'b1;
      end else if (idx == IW'(EN_W)) begin
        mem[EN_W] <= wdata & EN_MASK;
      end else if (idx == IW'(ST_W)) begin
        if (|(wdata & COMP)) begin
          mem[ST_W] <= mem[ST_W] & ~COMP;
          irq       <= 1'b0;
        end
      end else begin
        mem[idx] <= wdata;
      end
    end
  end

  logic wrp_wr, rdp_wr, st_wr;
  assign wrp_wr = wr_hit && (idx == IW'(WRP_W));
  assign rdp_wr = wr_hit && (idx == IW'(RDP_W));
  assign st_wr  = wr_hit && (idx == IW'(ST_W));

  p_endp_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem[ENDP_W][31:18] == 14'h0);
  p_rdp_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrp_wr |=> mem[RDP_W] == mem[WRP_W]);
  p_rdp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_wr && wdata != MAGIC) |=> ($stable(mem[RDP_W]) && $stable(armed)));
  p_swallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_wr && armed) |=> ($stable(mem[ST_W]) && $stable(irq) && !armed));
  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_wr && !armed && |(mem[EN_W] & COMP)) |=> irq);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && |(wdata & COMP)) |=> (!irq && (mem[ST_W] & COMP) == 32'h0));
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[ST_W] & ~COMP) == ST_RST);
  p_irq_backed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(mem[ST_W] & COMP));
endmodule

// File: tb/tb_dmaq_regs.sv
module tb_dmaq_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        we [2];
  logic [11:0] ad [2];
  logic [31:0] wd [2];
  logic [31:0] rd [2];
  logic        iq [2];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dmaq_regs #(.MAP_SEL(0)) dut (.clk(clk), .rst_n(rst_n), .wr_en(we[0]), .addr(ad[0]),
    .wdata(wd[0]), .rdata(rd[0]), .irq(iq[0]));
  dmaq_regs #(.MAP_SEL(1)) dut_b (.clk(clk), .rst_n(rst_n), .wr_en(we[1]), .addr(ad[1]),
    .wdata(wd[1]), .rdata(rd[1]), .irq(iq[1]));

  localparam logic [31:0] MAGIC = 32'hEE88_2266;
  localparam logic [31:0] PMASK = 32'h0003_FFFF;

  // k: 0 end, 1 write ptr, 2 read ptr, 3 enable, 4 status (R12)
  function automatic logic [11:0] off(int u, int k);
    logic [11:0] a [5];
    logic [11:0] b [5];
    a = '{12'h14, 12'h18, 12'h1C, 12'h20, 12'h24};
    b = '{12'h18, 12'h1C, 12'h20, 12'h38, 12'h3C};
    return (u == 0) ? a[k] : b[k];
  endfunction
  function automatic logic [31:0] comp(int u);
    return (u == 0) ? 32'h30 : 32'h30000;
  endfunction
  function automatic logic [31:0] enm(int u);
    return (u == 0) ? 32'hBFEFF07F : 32'h017003FF;
  endfunction

  task automatic chk(string req, int u, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s map%0d: actual=%08h expected=%08h", req, u, act, exp);
    end
  endtask

  task automatic wr(int u, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    we[u] = 1'b1; ad[u] = a; wd[u] = d;
    @(negedge clk);
    we[u] = 1'b0;
  endtask

  task automatic rdw(int u, logic [11:0] a, output logic [31:0] v);
    ad[u] = a;
    #1;
    v = rd[u];
  endtask

  task automatic t_reset(int u);
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      rdw(u, 12'(i * 4), v);
      chk("R1", u, v, (12'(i * 4) == off(u, 4)) ? 32'hF8000000 : 32'h0);
    end
    chk("R1 irq", u, 32'(iq[u]), 32'h0);
  endtask

  task automatic t_endp(int u);
    logic [31:0] v;
    wr(u, off(u, 0), 32'hFFFFFFFF);
    rdw(u, off(u, 0), v); chk("R2", u, v, 32'h0003FFFF);
    wr(u, off(u, 0), 32'h12345678);
    rdw(u, off(u, 0), v); chk("R2", u, v, 32'h12345678 & PMASK);
  endtask

  task automatic t_wrp(int u);
    logic [31:0] v;
    wr(u, off(u, 1), 32'hABCDEF12);
    rdw(u, off(u, 1), v); chk("R3 wrp", u, v, 32'hABCDEF12 & PMASK);
    rdw(u, off(u, 2), v); chk("R3 rdp copy", u, v, 32'hABCDEF12 & PMASK);
    rdw(u, off(u, 4), v); chk("R6 status", u, v, 32'hF8000000 | comp(u));
    chk("R6 no enable irq", u, 32'(iq[u]), 32'h0);
    wr(u, off(u, 4), comp(u));
    rdw(u, off(u, 4), v); chk("R8 cleared", u, v, 32'hF8000000);
  endtask

  task automatic t_magic(int u);
    logic [31:0] v;
    wr(u, off(u, 1), 32'h00000100);
    wr(u, off(u, 4), comp(u));
    wr(u, off(u, 2), 32'h12345678);
    rdw(u, off(u, 2), v); chk("R4 other value", u, v, 32'h100);
    wr(u, off(u, 1), 32'h00000200);
    rdw(u, off(u, 4), v); chk("R4 not armed", u, v, 32'hF8000000 | comp(u));
    wr(u, off(u, 4), comp(u));
    wr(u, off(u, 2), MAGIC);
    rdw(u, off(u, 2), v); chk("R4 magic keeps rdp", u, v, 32'h200);
    wr(u, off(u, 1), 32'h00000300);
    rdw(u, off(u, 4), v); chk("R5 swallowed", u, v, 32'hF8000000);
    rdw(u, off(u, 2), v); chk("R5 copy still", u, v, 32'h300);
    wr(u, off(u, 1), 32'h00000400);
    rdw(u, off(u, 4), v); chk("R5 one shot", u, v, 32'hF8000000 | comp(u));
    wr(u, off(u, 4), comp(u));
  endtask

  task automatic t_enable(int u);
    logic [31:0] v;
    wr(u, off(u, 3), 32'hFFFFFFFF);
    rdw(u, off(u, 3), v); chk("R7", u, v, enm(u));
    wr(u, off(u, 3), 32'h0);
    rdw(u, off(u, 3), v); chk("R7 zero", u, v, 32'h0);
  endtask

  task automatic t_irq(int u);
    logic [31:0] v;
    logic exp_irq;
    exp_irq = |(enm(u) & comp(u));
    wr(u, off(u, 3), 32'hFFFFFFFF);
    wr(u, off(u, 1), 32'h00000010);
    chk("R6 irq", u, 32'(iq[u]), 32'(exp_irq));
    wr(u, 12'h40, 32'h5A5A5A5A);
    wr(u, off(u, 0), 32'h1);
    chk("R11 held", u, 32'(iq[u]), 32'(exp_irq));
    wr(u, off(u, 4), ~comp(u));
    rdw(u, off(u, 4), v); chk("R8 no comp bit", u, v, 32'hF8000000 | comp(u));
    chk("R8 irq kept", u, 32'(iq[u]), 32'(exp_irq));
    wr(u, off(u, 4), comp(u) & ~(comp(u) << 1));
    rdw(u, off(u, 4), v); chk("R8 one bit clears both", u, v, 32'hF8000000);
    chk("R8 irq low", u, 32'(iq[u]), 32'h0);
    wr(u, off(u, 4), 32'hFFFFFFFF);
    rdw(u, off(u, 4), v); chk("R8 fixed bits", u, v, 32'hF8000000);
    wr(u, off(u, 3), 32'h0);
  endtask

  task automatic t_plain(int u);
    logic [31:0] v;
    wr(u, 12'h000, 32'hDEADBEEF);
    wr(u, 12'h0FC, 32'h01234567);
    rdw(u, 12'h000, v); chk("R9 low", u, v, 32'hDEADBEEF);
    rdw(u, 12'h0FC, v); chk("R9 high", u, v, 32'h01234567);
  endtask

  task automatic t_window(int u);
    logic [31:0] v;
    wr(u, 12'h100, 32'hCAFEF00D);
    wr(u, 12'h002, 32'h11111111);
    rdw(u, 12'h100, v); chk("R10 out read", u, v, 32'h0);
    rdw(u, 12'h002, v); chk("R10 misaligned read", u, v, 32'h0);
    rdw(u, 12'h000, v); chk("R10 no alias", u, v, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      we[u] = 1'b0; ad[u] = '0; wd[u] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int u = 0; u < 2; u++) begin
      t_reset(u);
      t_endp(u);
      t_wrp(u);
      t_magic(u);
      t_enable(u);
      t_irq(u);
      t_plain(u);
      t_window(u);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule